// File: doc/BRIEF.md
# Vector Element Broadcast Unit

This unit takes one element out of a 128-bit source vector and copies it into every lane of a 128-bit result. Elements are 8, 16, 32 or 64 bits wide. The unit decodes the 32-bit instruction word itself. From that word it finds the element width and where the lane index comes from. In the scalar-index form, the index comes from the low bits of a 64-bit scalar operand. In the immediate-index form, the index is carried inside the instruction word.

The surrounding pipeline supplies the source vector and the scalar operand and raises `in_valid` for one cycle. One clock edge later the unit presents the registered result together with `out_valid`. A word that matches no supported encoding does not produce a result. Instead it raises `illegal` for one cycle, and the result register keeps its previous contents. Register-file access, hazards, exceptions and any wider vector mode belong to the surrounding pipeline.

Top module: `vbc_broadcast_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `illegal` are 0 and `out_data` is all zeros.
- R2: The scalar-index form is recognised when instruction bits [31:17] equal 0111_0001_0010_001. Bits [16:15] select the element width: 00 is 8 bits, 01 is 16, 10 is 32 and 11 is 64. Bits [14:0] hold register numbers, and the unit ignores them.
- R3: In the scalar-index form, the lane index equals the scalar operand modulo the lane count (16, 8, 4 or 2 for widths 8, 16, 32 or 64). Scalar bits above bit 3 never change the result, and an index beyond the lane count wraps instead of faulting.
- R4: The immediate-index form is recognised when bits [31:15] equal 0111_0010_1111_0111_1. After that, bits [14:11] carry a unary prefix. If bit 14 is 0, the width is 8 bits and the index is bits [13:10]. If bits [14:13] are 10, the width is 16 and the index is bits [12:10]. If bits [14:12] are 110, the width is 32 and the index is bits [11:10]. If bits [14:11] are 1110, the width is 64 and the index is bit 10.
- R5: The chosen element is copied into every lane of `out_data` at the decoded width. Lane 0 occupies the least significant bits, and lane k occupies bits [k*W+W-1 : k*W].
- R6: A legal word accepted with `in_valid` high sets `out_valid` high and loads the result into `out_data` on the next rising clock edge.
- R7: A word accepted with `in_valid` high that matches neither form sets `illegal` high for one cycle. In that cycle `out_valid` is low and `out_data` is unchanged. This includes the immediate-form prefix followed by 1111 in bits [14:11].
- R8: In a cycle after `in_valid` was low, `out_valid` and `illegal` are 0 and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| vec_src | input | 128 | Source vector, lane 0 at the least significant bits |
| scalar_idx | input | 64 | Scalar operand used as the index in the scalar-index form |
| out_valid | output | 1 | Registered result is valid |
| illegal | output | 1 | Accepted word matched no supported encoding |
| out_data | output | 128 | Registered broadcast result |

## Verification
The assertions check several properties on every cycle. Recognised encodings always produce `out_valid` one cycle later, and the 1111 prefix always produces `illegal`. A result never appears without an accepted word, and `out_valid` and `illegal` are never high together. The result holds across idle cycles and illegal words. Every result repeats its 64-bit halves. In the byte-wide scalar-index form, lane 0 of the result equals the wrapped source byte. The bench scenarios are needed for the rest. They compare every lane for all four widths in both forms against a bench model that wraps the index by modulo. They also cover scalar operands whose upper bits are set, maximum immediate indices, and random or near-miss words that must be rejected.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
   typedef enum logic [1:0] {
      ESZ_8  = 2'd0,
      ESZ_16 = 2'd1,
      ESZ_32 = 2'd2,
      ESZ_64 = 2'd3
   } esize_e;

   typedef struct packed {
      logic       legal;
      logic       from_imm;
      esize_e     size;
      logic [3:0] imm_idx;
   } vbc_dec_t;

   // Fixed opcode fields; these values are what the decoder keys on.
   localparam logic [14:0] REG_FORM_HI = 15'b011100010010001;
   localparam logic [16:0] IMM_FORM_HI = 17'b01110010111101111;
   localparam int          NUM_SIZES   = 4;
endpackage

// File: rtl/vbc_decode.sv
module vbc_decode
   import vbc_pkg::*;
#(
   parameter int INSTR_W = 32
) (
   input  logic [INSTR_W-1:0] instr,
   output vbc_dec_t           dec
);
   if (INSTR_W != 32) begin : g_bad_instr_w
      $error("vbc_decode: INSTR_W must be 32");
   end

   // Register-number fields carry no meaning for this unit.
   wire unused_fields = ^instr[9:0];

   always_comb begin
      dec = '0;
      if (instr[31:17] == REG_FORM_HI) begin
         dec.legal    = 1'b1;
         dec.from_imm = 1'b0;
         dec.size     = esize_e'(instr[16:15]);
      end else if (instr[31:15] == IMM_FORM_HI) begin
         dec.from_imm = 1'b1;
         casez (instr[14:11])
            4'b0???: begin
               dec.legal   = 1'b1;
               dec.size    = ESZ_8;
               dec.imm_idx = instr[13:10];
            end
            4'b10??: begin
               dec.legal   = 1'b1;
               dec.size    = ESZ_16;
               dec.imm_idx = {1'b0, instr[12:10]};
            end
            4'b110?: begin
               dec.legal   = 1'b1;
               dec.size    = ESZ_32;
               dec.imm_idx = {2'b00, instr[11:10]};
            end
            4'b1110: begin
               dec.legal   = 1'b1;
               dec.size    = ESZ_64;
               dec.imm_idx = {3'b000, instr[10]};
            end
            default: dec.legal = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/vbc_index.sv
module vbc_index
   import vbc_pkg::*;
#(
   parameter int VEC_W    = 128,
   parameter int SCALAR_W = 64,
   localparam int MAX_LANES = VEC_W / 8,
   localparam int IDX_W     = $clog2(MAX_LANES)
) (
   input  vbc_dec_t            dec,
   input  logic [SCALAR_W-1:0] scalar,
   output logic [IDX_W-1:0]    idx
);
   if (SCALAR_W < IDX_W) begin : g_bad_scalar_w
      $error("vbc_index: SCALAR_W narrower than the lane index");
   end
   if (IDX_W != 4) begin : g_bad_idx_w
      $error("vbc_index: immediate fields assume a 16-lane byte view");
   end

   wire unused_scalar_hi = ^scalar[SCALAR_W-1:IDX_W];

   logic [IDX_W-1:0] raw;
   logic [IDX_W-1:0] mask;

   always_comb begin
      raw  = dec.from_imm ? dec.imm_idx : scalar[IDX_W-1:0];
      // lane count halves per size step; mask = lanes - 1
      mask = IDX_W'((MAX_LANES >> dec.size) - 1);
      idx  = raw & mask;
   end
endmodule

// File: rtl/vbc_lane_bcast.sv
module vbc_lane_bcast #(
   parameter int VEC_W = 128,
   parameter int EW    = 8,
   localparam int LANES = VEC_W / EW,
   localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [VEC_W-1:0] vec,
   input  logic [SEL_W-1:0] sel,
   output logic [VEC_W-1:0] dout
);
   if (VEC_W % EW != 0 || LANES < 2) begin : g_bad_ew
      $error("vbc_lane_bcast: EW must split VEC_W into at least two lanes");
   end

   logic [EW-1:0] lane [LANES];
   logic [EW-1:0] elem;

   for (genvar k = 0; k < LANES; k++) begin : g_unpack
      assign lane[k] = vec[k*EW +: EW];
   end

   assign elem = lane[sel];
   assign dout = {LANES{elem}};
endmodule

// File: rtl/vbc_broadcast_unit.sv
module vbc_broadcast_unit
   import vbc_pkg::*;
#(
   parameter int VEC_W    = 128,
   parameter int SCALAR_W = 64,
   parameter int INSTR_W  = 32,
   localparam int IDX_W   = $clog2(VEC_W / 8)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [INSTR_W-1:0]  instr,
   input  logic [VEC_W-1:0]    vec_src,
   input  logic [SCALAR_W-1:0] scalar_idx,
   output logic                out_valid,
   output logic                illegal,
   output logic [VEC_W-1:0]    out_data
);
   if (VEC_W != 128) begin : g_bad_vec_w
      $error("vbc_broadcast_unit: encodings define a 128-bit vector");
   end

   vbc_dec_t         dec;
   logic [IDX_W-1:0] idx;
   logic [VEC_W-1:0] cand [NUM_SIZES];
   logic [VEC_W-1:0] result;

   vbc_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   vbc_index #(.VEC_W(VEC_W), .SCALAR_W(SCALAR_W)) u_idx (
      .dec    (dec),
      .scalar (scalar_idx),
      .idx    (idx)
   );

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      localparam int EW = 8 << g;
      localparam int SW = $clog2(VEC_W / EW);
      vbc_lane_bcast #(.VEC_W(VEC_W), .EW(EW)) u_bc (
         .vec  (vec_src),
         .sel  (idx[SW-1:0]),
         .dout (cand[g])
      );
   end

   assign result = cand[dec.size];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         illegal   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid & dec.legal;
         illegal   <= in_valid & ~dec.legal;
         if (in_valid && dec.legal) begin
            out_data <= result;
         end
      end
   end
endmodule

// File: rtl/vbc_broadcast_unit_chk.sv
module vbc_broadcast_unit_chk
   import vbc_pkg::*;
(
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [31:0]  instr,
   input logic [127:0] vec_src,
   input logic [63:0]  scalar_idx,
   input logic         out_valid,
   input logic         illegal,
   input logic [127:0] out_data
);
   wire unused_chk = ^{instr[10:0], scalar_idx[63:4]};

   logic [7:0] byte_pick;
   logic       is_reg, is_imm, imm_bad;
   assign byte_pick = vec_src[{scalar_idx[3:0], 3'b000} +: 8];
   assign is_reg    = instr[31:17] == REG_FORM_HI;
   assign is_imm    = instr[31:15] == IMM_FORM_HI;
   assign imm_bad   = is_imm && instr[14:11] == 4'b1111;

   assert_reg_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && is_reg |=> out_valid && !illegal);

   assert_byte_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && is_reg && instr[16:15] == 2'b00 |=> out_data[7:0] == $past(byte_pick));

   assert_imm_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && is_imm && !imm_bad |=> out_valid);

   assert_halves_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_data[127:64] == out_data[63:0]);

   assert_needs_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   assert_bad_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && imm_bad |=> illegal);

   assert_hold_on_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> $stable(out_data) && !out_valid);

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !illegal && $stable(out_data));
endmodule

bind vbc_broadcast_unit vbc_broadcast_unit_chk u_chk (.*);

// File: tb/vbc_broadcast_unit_test.sv
module vbc_broadcast_unit_test;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  instr = '0;
   logic [127:0] vec_src = '0;
   logic [63:0]  scalar_idx = '0;
   logic         out_valid;
   logic         illegal;
   logic [127:0] out_data;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [127:0] held = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vbc_broadcast_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .vec_src(vec_src), .scalar_idx(scalar_idx),
      .out_valid(out_valid), .illegal(illegal), .out_data(out_data)
   );

   localparam logic [14:0] REG_HI = 15'b011100010010001;
   localparam logic [16:0] IMM_HI = 17'b01110010111101111;

   // Reference: returns {legal, result}; index wraps by modulo.
   function automatic logic [128:0] ref_op(input logic [31:0] w,
                                           input logic [127:0] v,
                                           input logic [63:0] s);
      int ew = 8;
      int idx = 0;
      logic ok = 1'b0;
      logic [127:0] r = '0;
      if (w[31:17] == REG_HI) begin
         ok  = 1'b1;
         ew  = 8 << w[16:15];
         idx = int'(s % 64'(128 / ew));
      end else if (w[31:15] == IMM_HI) begin
         if (!w[14]) begin ok = 1'b1; ew = 8;  idx = int'(w[13:10]); end
         else if (w[14:13] == 2'b10) begin ok = 1'b1; ew = 16; idx = int'(w[12:10]); end
         else if (w[14:12] == 3'b110) begin ok = 1'b1; ew = 32; idx = int'(w[11:10]); end
         else if (w[14:11] == 4'b1110) begin ok = 1'b1; ew = 64; idx = int'(w[10]); end
      end
      if (ok) begin
         for (int l = 0; l < 128 / ew; l++)
            for (int b = 0; b < ew; b++)
               r[l*ew + b] = v[idx*ew + b];
      end
      return {ok, r};
   endfunction

   function automatic logic [31:0] reg_word(input logic [1:0] sz);
      return {REG_HI, sz, 15'($urandom)};
   endfunction

   function automatic logic [31:0] imm_word(input logic [1:0] sz, input logic [3:0] ix);
      logic [4:0] f;
      case (sz)
         2'd0: f = {1'b0, ix};
         2'd1: f = {2'b10, ix[2:0]};
         2'd2: f = {3'b110, ix[1:0]};
         default: f = {4'b1110, ix[0]};
      endcase
      return {IMM_HI, f, 10'($urandom)};
   endfunction

   task automatic check(input string req, input logic ev, input logic ei,
                        input logic [127:0] ed);
      total++;
      if (out_valid !== ev || illegal !== ei || out_data !== ed) begin
         bad++;
         $display("FAIL %s: got v=%b i=%b d=%h, expected v=%b i=%b d=%h",
                  req, out_valid, illegal, out_data, ev, ei, ed);
      end
   endtask

   task automatic run_op(input string req, input logic [31:0] w,
                         input logic [127:0] v, input logic [63:0] s);
      logic [128:0] e;
      e = ref_op(w, v, s);
      in_valid = 1'b1; instr = w; vec_src = v; scalar_idx = s;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (e[128]) held = e[127:0];
      check(req, e[128], !e[128], held);
   endtask

   task automatic idle_cycle();
      instr = reg_word(2'($urandom));
      vec_src = {4{$urandom}};
      scalar_idx = {$urandom, $urandom};
      @(posedge clk);
      @(negedge clk);
      check("R8", 1'b0, 1'b0, held);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [127:0] v;
      void'($urandom(32'd7321));
      v = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
      repeat (3) @(negedge clk);
      check("R1", 1'b0, 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_cycle();

      // Directed: every width, scalar form, in range and wrapping.
      for (int sz = 0; sz < 4; sz++) begin
         int lanes = 16 >> sz;
         run_op("R2", reg_word(2'(sz)), v, 64'(lanes - 1));
         run_op("R3", reg_word(2'(sz)), v, 64'(lanes + 1));
         run_op("R3", reg_word(2'(sz)), v, 64'hFFFF_FFFF_FFFF_FFF0 | 64'(sz));
         run_op("R5", reg_word(2'(sz)), {4{$urandom}}, 64'd0);
      end
      // Directed: immediate form, index 0 and maximum.
      for (int sz = 0; sz < 4; sz++) begin
         run_op("R4", imm_word(2'(sz), 4'hF), v, 64'h5);
         run_op("R4", imm_word(2'(sz), 4'h0), {4{$urandom}}, 64'hFFFF);
      end
      // Illegal: 1111 prefix, then a legal op, then near misses.
      run_op("R7", {IMM_HI, 5'b11110, 10'h3FF}, v, 64'd0);
      run_op("R7", {IMM_HI, 5'b11111, 10'h000}, {4{$urandom}}, 64'd1);
      run_op("R6", reg_word(2'd1), {4{$urandom}}, 64'd3);
      run_op("R7", {REG_HI ^ 15'h0001, 2'b00, 15'h0}, {4{$urandom}}, 64'd2);
      run_op("R7", 32'h0, {4{$urandom}}, 64'd0);
      idle_cycle();

      // Random mix.
      for (int n = 0; n < 400; n++) begin
         logic [31:0] w;
         int kind = int'($urandom % 5);
         case (kind)
            0: w = reg_word(2'($urandom));
            1: w = imm_word(2'($urandom), 4'($urandom));
            2: w = {IMM_HI, 4'b1111, 11'($urandom)};
            3: w = $urandom;
            default: w = reg_word(2'($urandom)) ^ (32'h1 << (17 + ($urandom % 15)));
         endcase
         run_op(kind == 0 ? "R3" : kind == 1 ? "R4" : "R7", w,
                {4{$urandom}}, {$urandom, $urandom});
         if (($urandom % 8) == 0) idle_cycle();
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule